// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block prepares the second operand of a data-processing unit. It takes a data word and a two-bit shift kind: logical left, logical right, arithmetic right or rotate right. It shifts the word by an amount that comes either from a short immediate field or from a register. It returns the shifted word together with the shifter carry-out. The carry-out is the last bit moved out of the word, or the incoming carry when nothing moves.

Two amounts get special treatment. A zero immediate amount is not taken as a shift of zero for every kind. Each kind reads it differently: a full-width shift, a one-bit rotate through the carry, or a plain pass-through. Register amounts are eight bits wide. Any register amount equal to or wider than the data word saturates, and each kind has its own carry rule for that case.

A separate path builds an immediate operand from an eight-bit constant and a four-bit rotate field. When that path is selected, the shift inputs are ignored. Both outputs are registered, so a result appears one clock after its inputs. A synchronous active-high reset clears both outputs.

Top module: `opshift_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result` and `carry_out` become 0 after that edge. Otherwise both outputs show, after each rising edge, the function of the inputs sampled at that edge.
- R2: Immediate mode (`amt_from_reg`=0) with kind 0 (logical left) and amount 0 passes `op_value` unchanged, and `carry_out` equals `carry_in`.
- R3: Immediate mode, kind 1 (logical right), amount 0 acts as a shift by 32. The result is 0 and `carry_out` is `op_value[31]`.
- R4: Immediate mode, kind 2 (arithmetic right), amount 0 acts as a shift by 32. Every result bit equals `op_value[31]`, and so does `carry_out`.
- R5: Immediate mode, kind 3 (rotate right), amount 0 is a one-bit rotate through carry. The result is `{carry_in, op_value[31:1]}` and `carry_out` is `op_value[0]`.
- R6: Kind encoding: 0 is logical left, 1 logical right, 2 arithmetic right, 3 rotate right. For an amount n from 1 to 31 in either mode, the result is the standard shift or rotate. `carry_out` is `op_value[32-n]` for a left shift and `op_value[n-1]` for the other kinds.
- R7: Register mode (`amt_from_reg`=1) with `reg_amt`=0 passes `op_value` unchanged, with `carry_out`=`carry_in`, for every kind.
- R8: Register mode, logical shifts by exactly 32 give a zero result. The carry is `op_value[0]` for a left shift and `op_value[31]` for a right shift. Logical shifts by 33 to 255 give a zero result and a zero carry.
- R9: Register mode, an arithmetic right shift by 32 to 255 fills the result with `op_value[31]`, and `carry_out` is `op_value[31]`.
- R10: Register mode, rotate right uses `reg_amt` modulo 32. A nonzero amount whose low five bits are zero returns `op_value` unchanged, with `carry_out`=`op_value[31]`.
- R11: When `use_const`=1, the result is `const_byte`, zero-extended and rotated right by 2×`const_rot`. `carry_out` is `carry_in` when `const_rot`=0 and result bit 31 otherwise. The shift inputs have no effect on this path.
- R12: `imm_amt` has no effect in register mode, and `reg_amt` has no effect in immediate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_value | input | 32 | Data word to shift |
| op_kind | input | 2 | Shift kind (0 LSL, 1 LSR, 2 ASR, 3 ROR) |
| amt_from_reg | input | 1 | 1: amount from `reg_amt`, 0: from `imm_amt` |
| imm_amt | input | 5 | Immediate shift amount |
| reg_amt | input | 8 | Register shift amount |
| carry_in | input | 1 | Current carry flag |
| use_const | input | 1 | Select the rotated-constant path |
| const_byte | input | 8 | Constant for the rotated immediate |
| const_rot | input | 4 | Rotate field (rotation is twice this value) |
| result | output | 32 | Registered shifted operand |
| carry_out | output | 1 | Registered shifter carry-out |

## Verification
Both the shifted word and the carry-out are due exactly one rising edge after the inputs that produce them, and the reset clear is also seen one edge later. The bench changes inputs on the falling edge. It compares the outputs at the next falling edge, which follows the single capturing rising edge, so every comparison lands half a period after the result register has loaded. The expected values come from a bit-by-bit stepping model, not from a barrel structure. Directed cases cover amounts 0, 1, 31, 32, 33 and 255 for every kind and mode, and a seeded random stream covers the rest.

// File: rtl/opshift_pkg.sv
`timescale 1ns/1ps
package opshift_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/opshift_amount_norm.sv
`timescale 1ns/1ps
// Turns the raw amount fields into an effective amount 0..WIDTH plus two
// special-case flags (rotate through carry, logical flush to zero).
module opshift_amount_norm
  import opshift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = $clog2(WIDTH),
  parameter int REG_W = 8,
  parameter int SH_W  = IMM_W + 1
) (
  input  shift_kind_e      kind,
  input  logic             from_reg,
  input  logic [IMM_W-1:0] imm_amt,
  input  logic [REG_W-1:0] reg_amt,
  output logic [SH_W-1:0]  eff_amt,
  output logic             rrx,
  output logic             flush
);
  localparam logic [SH_W-1:0] FULL = SH_W'(WIDTH);

  logic [IMM_W-1:0] low_bits;
  logic             reg_full;
  logic             reg_over;

  assign low_bits = reg_amt[IMM_W-1:0];
  assign reg_full = (32'(reg_amt) >= 32'(WIDTH));
  assign reg_over = (32'(reg_amt) >  32'(WIDTH));

  always_comb begin
    eff_amt = '0;
    rrx     = 1'b0;
    flush   = 1'b0;
    if (!from_reg) begin
      unique case (kind)
        SH_LSL: eff_amt = SH_W'(imm_amt);
        SH_LSR, SH_ASR: eff_amt = (imm_amt == '0) ? FULL : SH_W'(imm_amt);
        default: begin
          if (imm_amt == '0) rrx = 1'b1;
          else               eff_amt = SH_W'(imm_amt);
        end
      endcase
    end else begin
      unique case (kind)
        SH_LSL, SH_LSR: begin
          if (reg_over) flush   = 1'b1;
          else          eff_amt = SH_W'(reg_amt);
        end
        SH_ASR: eff_amt = reg_full ? FULL : SH_W'(reg_amt);
        default: begin
          if (reg_amt == '0)       eff_amt = '0;
          else if (low_bits == '0) eff_amt = FULL;
          else                     eff_amt = SH_W'(low_bits);
        end
      endcase
    end
  end
endmodule

// File: rtl/opshift_barrel.sv
`timescale 1ns/1ps
// Logarithmic right-shift network; left shifts reuse it through bit reversal.
module opshift_barrel
  import opshift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SH_W  = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] value,
  input  shift_kind_e      kind,
  input  logic [SH_W-1:0]  amt,
  input  logic             rrx,
  input  logic             flush,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             cout
);
  localparam int IDX_W = SH_W - 1;
  localparam logic [SH_W-1:0] FULL = SH_W'(WIDTH);

  logic is_left, is_rot, is_ari, sign;
  logic [SH_W:0][WIDTH-1:0] stg;
  logic [WIDTH-1:0] net;
  logic [SH_W-1:0]  lidx, ridx;

  assign is_left = (kind == SH_LSL);
  assign is_rot  = (kind == SH_ROR);
  assign is_ari  = (kind == SH_ASR);
  assign sign    = value[WIDTH-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_in
    assign stg[0][i] = is_left ? value[WIDTH-1-i] : value[i];
  end

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int STEP = 2 ** k;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i + STEP < WIDTH) begin : g_mid
        assign stg[k+1][i] = amt[k] ? stg[k][i+STEP] : stg[k][i];
      end else begin : g_edge
        assign stg[k+1][i] = amt[k]
                           ? (is_rot ? stg[k][(i+STEP)%WIDTH] : (is_ari & sign))
                           : stg[k][i];
      end
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_out
    assign net[i] = is_left ? stg[SH_W][WIDTH-1-i] : stg[SH_W][i];
  end

  assign lidx = FULL - amt;
  assign ridx = amt - 1'b1;

  always_comb begin
    if (rrx) begin
      res  = {cin, value[WIDTH-1:1]};
      cout = value[0];
    end else if (flush) begin
      res  = '0;
      cout = 1'b0;
    end else if (amt == '0) begin
      res  = value;
      cout = cin;
    end else begin
      res  = net;
      cout = is_left ? value[lidx[IDX_W-1:0]] : value[ridx[IDX_W-1:0]];
    end
  end
endmodule

// File: rtl/opshift_const_rot.sv
`timescale 1ns/1ps
// Zero-extended constant rotated right by twice the rotate field.
module opshift_const_rot #(
  parameter int WIDTH   = 32,
  parameter int CONST_W = 8,
  parameter int ROT_W   = 4
) (
  input  logic [CONST_W-1:0] cbyte,
  input  logic [ROT_W-1:0]   rot,
  input  logic               cin,
  output logic [WIDTH-1:0]   res,
  output logic               cout
);
  logic [ROT_W:0][WIDTH-1:0] stg;

  assign stg[0] = WIDTH'(cbyte);

  for (genvar j = 0; j < ROT_W; j++) begin : g_stage
    localparam int STEP = 2 * (2 ** j);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign stg[j+1][i] = rot[j] ? stg[j][(i+STEP)%WIDTH] : stg[j][i];
    end
  end

  assign res  = stg[ROT_W];
  assign cout = (rot == '0) ? cin : stg[ROT_W][WIDTH-1];
endmodule

// File: rtl/opshift_unit.sv
`timescale 1ns/1ps
module opshift_unit
  import opshift_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int IMM_W   = $clog2(WIDTH),
  parameter int REG_W   = 8,
  parameter int CONST_W = 8,
  parameter int ROT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WIDTH-1:0]   op_value,
  input  logic [1:0]         op_kind,
  input  logic               amt_from_reg,
  input  logic [IMM_W-1:0]   imm_amt,
  input  logic [REG_W-1:0]   reg_amt,
  input  logic               carry_in,
  input  logic               use_const,
  input  logic [CONST_W-1:0] const_byte,
  input  logic [ROT_W-1:0]   const_rot,
  output logic [WIDTH-1:0]   result,
  output logic               carry_out
);
  localparam int SH_W = IMM_W + 1;

  shift_kind_e      kind;
  logic [SH_W-1:0]  eff_amt;
  logic             rrx, flush;
  logic [WIDTH-1:0] sh_res, k_res, nxt_res;
  logic             sh_c, k_c, nxt_c;

  assign kind = shift_kind_e'(op_kind);

  opshift_amount_norm #(.WIDTH(WIDTH), .IMM_W(IMM_W), .REG_W(REG_W), .SH_W(SH_W)) u_norm (
    .kind(kind), .from_reg(amt_from_reg), .imm_amt(imm_amt), .reg_amt(reg_amt),
    .eff_amt(eff_amt), .rrx(rrx), .flush(flush)
  );

  opshift_barrel #(.WIDTH(WIDTH), .SH_W(SH_W)) u_barrel (
    .value(op_value), .kind(kind), .amt(eff_amt), .rrx(rrx), .flush(flush),
    .cin(carry_in), .res(sh_res), .cout(sh_c)
  );

  opshift_const_rot #(.WIDTH(WIDTH), .CONST_W(CONST_W), .ROT_W(ROT_W)) u_const (
    .cbyte(const_byte), .rot(const_rot), .cin(carry_in), .res(k_res), .cout(k_c)
  );

  assign nxt_res = use_const ? k_res : sh_res;
  assign nxt_c   = use_const ? k_c   : sh_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
    end else begin
      result    <= nxt_res;
      carry_out <= nxt_c;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (result == '0 && !carry_out));

  assert_lsr_imm0_R3: assert property (@(posedge clk) disable iff (rst)
    (!use_const && !amt_from_reg && op_kind == 2'd1 && imm_amt == '0)
    |=> (result == '0 && carry_out == $past(op_value[WIDTH-1])));

  assert_rrx_R5: assert property (@(posedge clk) disable iff (rst)
    (!use_const && !amt_from_reg && op_kind == 2'd3 && imm_amt == '0)
    |=> (result == {$past(carry_in), $past(op_value[WIDTH-1:1])}
         && carry_out == $past(op_value[0])));

  assert_reg_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (!use_const && amt_from_reg && reg_amt == '0)
    |=> (result == $past(op_value) && carry_out == $past(carry_in)));

  assert_logic_over_R8: assert property (@(posedge clk) disable iff (rst)
    (!use_const && amt_from_reg && !op_kind[1] && 32'(reg_amt) > 32'(WIDTH))
    |=> (result == '0 && !carry_out));

  assert_asr_sat_R9: assert property (@(posedge clk) disable iff (rst)
    (!use_const && amt_from_reg && op_kind == 2'd2 && 32'(reg_amt) >= 32'(WIDTH))
    |=> (result == {WIDTH{$past(op_value[WIDTH-1])}}
         && carry_out == $past(op_value[WIDTH-1])));

  assert_const_norot_R11: assert property (@(posedge clk) disable iff (rst)
    (use_const && const_rot == '0)
    |=> (result == WIDTH'($past(const_byte)) && carry_out == $past(carry_in)));
endmodule

// File: tb/opshift_unit_bench.sv
`timescale 1ns/1ps
module opshift_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] op_value;
  logic [1:0]  op_kind;
  logic        amt_from_reg;
  logic [4:0]  imm_amt;
  logic [7:0]  reg_amt;
  logic        carry_in;
  logic        use_const;
  logic [7:0]  const_byte;
  logic [3:0]  const_rot;
  logic [31:0] result;
  logic        carry_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  opshift_unit u_opshift_unit (
    .clk(clk), .rst(rst), .op_value(op_value), .op_kind(op_kind),
    .amt_from_reg(amt_from_reg), .imm_amt(imm_amt), .reg_amt(reg_amt),
    .carry_in(carry_in), .use_const(use_const), .const_byte(const_byte),
    .const_rot(const_rot), .result(result), .carry_out(carry_out)
  );

  // Stepping model: one bit per iteration.
  function automatic logic [32:0] ref_shift(input logic [31:0] v, input logic [1:0] k,
      input logic isreg, input logic [4:0] ia, input logic [7:0] ra, input logic ci);
    logic [31:0] x;
    logic c;
    int n;
    x = v; c = ci;
    if (!isreg) begin
      n = int'(ia);
      if (n == 0) begin
        case (k)
          2'd0: ;
          2'd1: begin x = '0; c = v[31]; end
          2'd2: begin x = {32{v[31]}}; c = v[31]; end
          default: begin x = {ci, v[31:1]}; c = v[0]; end
        endcase
        return {c, x};
      end
    end else begin
      n = int'(ra);
      if (k == 2'd3 && n != 0) begin
        n = n % 32;
        if (n == 0) return {v[31], v};
      end
    end
    for (int s = 0; s < n; s++) begin
      case (k)
        2'd0: begin c = x[31]; x = {x[30:0], 1'b0}; end
        2'd1: begin c = x[0];  x = {1'b0, x[31:1]}; end
        2'd2: begin c = x[0];  x = {x[31], x[31:1]}; end
        default: begin c = x[0]; x = {x[0], x[31:1]}; end
      endcase
    end
    return {c, x};
  endfunction

  function automatic logic [32:0] ref_const(input logic [7:0] b, input logic [3:0] r,
      input logic ci);
    logic [31:0] x;
    x = {24'd0, b};
    for (int s = 0; s < 2 * int'(r); s++) x = {x[0], x[31:1]};
    return {(r == 4'd0) ? ci : x[31], x};
  endfunction

  function automatic string tag_of(input logic [1:0] k, input logic isreg,
      input logic [4:0] ia, input logic [7:0] ra);
    if (!isreg && ia == 5'd0)
      return (k == 2'd0) ? "R2" : (k == 2'd1) ? "R3" : (k == 2'd2) ? "R4" : "R5";
    if (isreg && ra == 8'd0) return "R7";
    if (isreg && ra >= 8'd32)
      return (k[1] == 1'b0) ? "R8" : (k == 2'd2) ? "R9" : "R10";
    if (isreg && k == 2'd3) return "R10";
    return "R6";
  endfunction

  task automatic check(input string tag, input logic [32:0] exp);
    checks++;
    if ({carry_out, result} !== exp) begin
      errors++;
      $display("FAIL %s: got c=%0b r=%08h, expected c=%0b r=%08h",
               tag, carry_out, result, exp[32], exp[31:0]);
    end
  endtask

  task automatic drive(input logic [31:0] v, input logic [1:0] k, input logic isreg,
      input logic [4:0] ia, input logic [7:0] ra, input logic ci, input logic uc,
      input logic [7:0] cb, input logic [3:0] cr);
    @(negedge clk);
    op_value = v; op_kind = k; amt_from_reg = isreg; imm_amt = ia; reg_amt = ra;
    carry_in = ci; use_const = uc; const_byte = cb; const_rot = cr;
    @(negedge clk);
  endtask

  task automatic run_shift(input logic [31:0] v, input logic [1:0] k, input logic isreg,
      input logic [4:0] ia, input logic [7:0] ra, input logic ci);
    drive(v, k, isreg, ia, ra, ci, 1'b0, 8'h5A, 4'h7);
    check(tag_of(k, isreg, ia, ra), ref_shift(v, k, isreg, ia, ra, ci));
  endtask

  task automatic run_const(input logic [7:0] cb, input logic [3:0] cr, input logic ci,
      input logic [31:0] v, input logic [7:0] ra);
    drive(v, 2'd2, 1'b1, 5'd9, ra, ci, 1'b1, cb, cr);
    check("R11", ref_const(cb, cr, ci));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [3];
    logic [7:0]  ramts [6];
    logic [4:0]  iamts [4];
    vals[0] = 32'h8000_0001; vals[1] = 32'h7FFF_FFFE; vals[2] = 32'hA5C3_0F96;
    ramts[0] = 8'd0; ramts[1] = 8'd1; ramts[2] = 8'd31;
    ramts[3] = 8'd32; ramts[4] = 8'd33; ramts[5] = 8'd255;
    iamts[0] = 5'd0; iamts[1] = 5'd1; iamts[2] = 5'd16; iamts[3] = 5'd31;
    void'($urandom(32'd4242));

    rst = 1'b1; op_value = 32'hFFFF_FFFF; op_kind = 2'd3; amt_from_reg = 1'b0;
    imm_amt = 5'd0; reg_amt = 8'd0; carry_in = 1'b1; use_const = 1'b0;
    const_byte = 8'hFF; const_rot = 4'd0;
    repeat (3) @(negedge clk);
    check("R1", 33'd0);
    rst = 1'b0;

    for (int k = 0; k < 4; k++)
      for (int vi = 0; vi < 3; vi++)
        for (int ci = 0; ci < 2; ci++) begin
          for (int a = 0; a < 4; a++)
            run_shift(vals[vi], 2'(k), 1'b0, iamts[a], 8'd0, 1'(ci));
          for (int a = 0; a < 6; a++)
            run_shift(vals[vi], 2'(k), 1'b1, 5'd0, ramts[a], 1'(ci));
          run_shift(vals[vi], 2'(k), 1'b1, 5'd0, 8'd64, 1'(ci));
          run_shift(vals[vi], 2'(k), 1'b1, 5'd0, 8'd100, 1'(ci));
        end

    // R12: the unused amount field carries noise
    for (int k = 0; k < 4; k++) begin
      drive(32'hC001_D00D, 2'(k), 1'b1, 5'd17, 8'd3, 1'b0, 1'b0, 8'h00, 4'h0);
      check("R12", ref_shift(32'hC001_D00D, 2'(k), 1'b1, 5'd0, 8'd3, 1'b0));
      drive(32'hC001_D00D, 2'(k), 1'b0, 5'd5, 8'd200, 1'b1, 1'b0, 8'h00, 4'h0);
      check("R12", ref_shift(32'hC001_D00D, 2'(k), 1'b0, 5'd5, 8'd0, 1'b1));
    end

    for (int r = 0; r < 16; r++) begin
      run_const(8'hC3, 4'(r), 1'b0, 32'h1234_5678, 8'd40);
      run_const(8'h81, 4'(r), 1'b1, 32'hFFFF_0000, 8'd0);
    end

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] v;
      logic [31:0] sel;
      v = $urandom; sel = $urandom;
      if (sel[3:0] == 4'd0)
        run_const(v[7:0], v[11:8], sel[4], $urandom, 8'($urandom));
      else
        run_shift(v, sel[5:4], sel[6], sel[11:7], sel[19:12], sel[20]);
    end

    drive(32'hDEAD_BEEF, 2'd1, 1'b0, 5'd4, 8'd0, 1'b1, 1'b0, 8'h0, 4'h0);
    rst = 1'b1;
    @(negedge clk);
    check("R1", 33'd0);
    rst = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule